// File: doc/BRIEF.md
# Sample Ring Buffer with Interrupt Flags

This block holds conversion samples in a circular store of a fixed, not necessarily power-of-two, number of words. An acquisition engine presents one sample per cycle while acquisition is running; each accepted sample is written at the producer index, and that index then steps forward. A host drains the store through a read port at addresses of its choosing. It then hands back its consumer index by writing it into a register, which frees the drained slots.

The number of stored samples is derived from the two indices, with an explicit wrap correction because the depth is arbitrary. A programmable fill level raises a block-ready flag. The flag register holds eight event bits. The host enables each bit through a mask, clears a bit by writing a one to it, and receives a single interrupt line that is the OR of the enabled flags. A push onto a full ring is refused and raised as a converter hardware fault. A converter fault of either kind ends acquisition until the host restarts it.

Top module: `smp_ring_irq`

## Requirements
- R1: After reset the producer index, consumer index, fill count, flag register, mask register and threshold are all zero, acquisition is stopped and `irq` is low.
- R2: A sample presented with `smp_valid` while acquisition runs and the ring is not full is written at `front_idx`, and `front_idx` then advances by one, going from DEPTH-1 to 0.
- R3: `fill_cnt` equals `front_idx - rear_idx` when that is not negative, and `front_idx - rear_idx + DEPTH` otherwise. A push and a consumer-index write in the same cycle both take effect.
- R4: A write of `rear_wdata` with `rear_wr` loads the consumer index. A value of DEPTH or more is ignored and the index keeps its old value.
- R5: Flag bit 0 (block ready) is set on the edge where an accepted sample makes the fill count equal to a nonzero threshold. The threshold is loaded by `thr_wr`, and a threshold of zero never sets the flag.
- R6: When advancing the producer index would make it equal to the consumer index, the sample is dropped, `front_idx` and the stored data are unchanged, and flag bit 2 (converter hardware fault) is set.
- R7: Setting flag bit 1 (converter software fault) or bit 2 stops acquisition on the same edge. While stopped, presented samples are ignored. An error wins over a start pulse in the same cycle.
- R8: Each one in `flag_clr` clears the matching flag bit. If a bit is set and cleared in the same cycle, the set wins.
- R9: `irq` is high exactly when some flag bit and its mask bit are both one. A mask of zero keeps `irq` low.
- R10: Each one in `evt_set` sets the matching flag bit. The bit meanings are: 0 block ready, 1 converter software fault, 2 converter hardware fault, 3 output empty, 4 output software fault, 5 output hardware fault, 6 timer done, 7 command done.
- R11: `host_rd_data` shows the word stored at `host_rd_addr` one cycle after the address is presented.
- R12: `acq_start` starts acquisition and `acq_stop` stops it. Samples are accepted only while `acq_running` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_start | input | 1 | Pulse: start accepting samples |
| acq_stop | input | 1 | Pulse: stop accepting samples |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | DATA_W | Sample word |
| host_rd_addr | input | IDX_W | Host read address into the ring |
| host_rd_data | output | DATA_W | Word at the read address, one cycle later |
| rear_wr | input | 1 | Load consumer index |
| rear_wdata | input | IDX_W | New consumer index |
| thr_wr | input | 1 | Load fill threshold |
| thr_wdata | input | IDX_W | New fill threshold |
| mask_wr | input | 1 | Load interrupt mask |
| mask_wdata | input | 8 | New interrupt mask |
| flag_clr | input | 8 | Write-one-to-clear flag bits |
| evt_set | input | 8 | Event pulses that set flag bits |
| front_idx | output | IDX_W | Producer index |
| rear_idx | output | IDX_W | Consumer index |
| fill_cnt | output | IDX_W | Number of stored samples |
| acq_running | output | 1 | Acquisition active |
| flags | output | 8 | Flag register |
| irq_mask | output | 8 | Mask register |
| irq | output | 1 | Masked interrupt request |

## Verification
Two pairs of functions can collide in one cycle, and both are provoked on purpose. In the first, a sample reaches the threshold while the host writes a one to clear block ready; the flag is then read after the edge and must still be set. In the second, a push and a consumer-index write share a cycle; both indices and the fill count are then compared with values worked out by hand. The full-ring refusal is reached by pushing one sample more than the capacity, and the wrap of the producer index is then exercised by restarting at the end of the ring.

// File: rtl/smp_ring_pkg.sv
package smp_ring_pkg;

   localparam int FLAG_W = 8;

   // flag bit positions (the host decodes these)
   localparam int F_BLK   = 0;
   localparam int F_ADSW  = 1;
   localparam int F_ADHW  = 2;
   localparam int F_DAEMP = 3;
   localparam int F_DASW  = 4;
   localparam int F_DAHW  = 5;
   localparam int F_TMR   = 6;
   localparam int F_CMD   = 7;

   typedef logic [FLAG_W-1:0] flag_vec_t;

   // next index with explicit compare-and-wrap (depth need not be 2^n)
   function automatic int unsigned ring_step(int unsigned idx, int unsigned depth);
      return (idx + 1 >= depth) ? 0 : idx + 1;
   endfunction

   // distance from tail to head around the ring
   function automatic int unsigned ring_dist(int unsigned head, int unsigned tail,
                                             int unsigned depth);
      return (head >= tail) ? head - tail : head + depth - tail;
   endfunction

endpackage

// File: rtl/ring_idx_ctrl.sv
module ring_idx_ctrl
   import smp_ring_pkg::*;
#(
   parameter int DEPTH = 2003,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_req,
   input  logic             rear_wr,
   input  logic [IDX_W-1:0] rear_wdata,
   output logic [IDX_W-1:0] front_q,
   output logic [IDX_W-1:0] rear_q,
   output logic [IDX_W-1:0] fill,
   output logic [IDX_W-1:0] fill_nxt,
   output logic             full,
   output logic             push_ok,
   output logic             drop
);

   localparam int unsigned DEPTH_U = DEPTH;

   generate
      if (DEPTH < 2 || (2 ** IDX_W) < DEPTH) begin : g_bad_cfg
         $error("ring_idx_ctrl: DEPTH must be >= 2 and fit in IDX_W bits");
      end
   endgenerate

   logic [IDX_W-1:0] front_step;
   logic [IDX_W-1:0] front_d;
   logic [IDX_W-1:0] rear_d;
   logic             rear_ok;

   always_comb begin
      front_step = IDX_W'(ring_step(32'(front_q), DEPTH_U));
      full       = (front_step == rear_q);
      push_ok    = push_req && !full;
      drop       = push_req && full;
      rear_ok    = rear_wr && (32'(rear_wdata) < DEPTH_U);
      front_d    = push_ok ? front_step : front_q;
      rear_d     = rear_ok ? rear_wdata : rear_q;
      fill       = IDX_W'(ring_dist(32'(front_q), 32'(rear_q), DEPTH_U));
      fill_nxt   = IDX_W'(ring_dist(32'(front_d), 32'(rear_d), DEPTH_U));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         front_q <= '0;
         rear_q  <= '0;
      end else begin
         front_q <= front_d;
         rear_q  <= rear_d;
      end
   end

endmodule

// File: rtl/ring_store.sv
module ring_store #(
   parameter int DEPTH    = 2003,
   parameter int DATA_W   = 16,
   parameter int IDX_W    = $clog2(DEPTH),
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned DEPTH_U = DEPTH;

   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("ring_store: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rd_word;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_comb begin
      rd_word = (32'(raddr) < DEPTH_U) ? mem[raddr] : '0;
   end

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk) rdata <= rd_word;
      end else begin : g_rd_comb
         always_comb rdata = rd_word;
      end
   endgenerate

endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
   import smp_ring_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  flag_vec_t set_vec,
   input  flag_vec_t clr_vec,
   input  logic      mask_wr,
   input  flag_vec_t mask_wdata,
   output flag_vec_t flags_q,
   output flag_vec_t mask_q,
   output logic      irq
);

   genvar b;
   generate
      for (b = 0; b < FLAG_W; b++) begin : g_bit
         // set has priority over a same-cycle clear
         always_ff @(posedge clk) begin
            if (!rst_n)            flags_q[b] <= 1'b0;
            else if (set_vec[b])   flags_q[b] <= 1'b1;
            else if (clr_vec[b])   flags_q[b] <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= mask_wdata;
   end

   always_comb irq = |(flags_q & mask_q);

endmodule

// File: rtl/smp_ring_irq.sv
module smp_ring_irq
   import smp_ring_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int DEPTH    = 2003,
   parameter int IDX_W    = $clog2(DEPTH),
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acq_start,
   input  logic              acq_stop,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [IDX_W-1:0]  host_rd_addr,
   output logic [DATA_W-1:0] host_rd_data,
   input  logic              rear_wr,
   input  logic [IDX_W-1:0]  rear_wdata,
   input  logic              thr_wr,
   input  logic [IDX_W-1:0]  thr_wdata,
   input  logic              mask_wr,
   input  logic [7:0]        mask_wdata,
   input  logic [7:0]        flag_clr,
   input  logic [7:0]        evt_set,
   output logic [IDX_W-1:0]  front_idx,
   output logic [IDX_W-1:0]  rear_idx,
   output logic [IDX_W-1:0]  fill_cnt,
   output logic              acq_running,
   output logic [7:0]        flags,
   output logic [7:0]        irq_mask,
   output logic              irq
);

   generate
      if (FLAG_W != 8) begin : g_bad_flags
         $error("smp_ring_irq: flag register must be 8 bits");
      end
   endgenerate

   logic             run_q;
   logic [IDX_W-1:0] thr_q;
   logic             acc_req;
   logic             ring_full;
   logic             push_ok;
   logic             push_drop;
   logic [IDX_W-1:0] fill_nxt;
   logic             blk_hit;
   logic             err_now;
   flag_vec_t        set_vec;

   assign acc_req = smp_valid && run_q;

   ring_idx_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (acc_req),
      .rear_wr   (rear_wr),
      .rear_wdata(rear_wdata),
      .front_q   (front_idx),
      .rear_q    (rear_idx),
      .fill      (fill_cnt),
      .fill_nxt  (fill_nxt),
      .full      (ring_full),
      .push_ok   (push_ok),
      .drop      (push_drop)
   );

   ring_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W),
                .READ_REG(READ_REG)) u_store (
      .clk  (clk),
      .we   (push_ok),
      .waddr(front_idx),
      .wdata(smp_data),
      .raddr(host_rd_addr),
      .rdata(host_rd_data)
   );

   always_comb begin
      blk_hit = push_ok && (thr_q != '0) && (fill_nxt == thr_q);
      set_vec = evt_set;
      set_vec[F_BLK]  = evt_set[F_BLK]  | blk_hit;
      set_vec[F_ADHW] = evt_set[F_ADHW] | push_drop;
      err_now = set_vec[F_ADSW] | set_vec[F_ADHW];
   end

   irq_flag_reg u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_vec   (set_vec),
      .clr_vec   (flag_clr),
      .mask_wr   (mask_wr),
      .mask_wdata(mask_wdata),
      .flags_q   (flags),
      .mask_q    (irq_mask),
      .irq       (irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         thr_q <= '0;
      end else begin
         if (err_now)        run_q <= 1'b0;
         else if (acq_start) run_q <= 1'b1;
         else if (acq_stop)  run_q <= 1'b0;
         if (thr_wr) thr_q <= thr_wdata;
      end
   end

   assign acq_running = run_q;

endmodule

// File: rtl/smp_ring_chk.sv
module smp_ring_chk #(
   parameter int DEPTH = 2003,
   parameter int IDX_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_req,
   input logic             ring_full,
   input logic [IDX_W-1:0] front_idx,
   input logic [IDX_W-1:0] rear_idx,
   input logic [IDX_W-1:0] fill_cnt,
   input logic [7:0]       flags,
   input logic [7:0]       irq_mask,
   input logic             irq,
   input logic             acq_running
);

   AST_FRONT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(front_idx) < DEPTH); // R2

   AST_REAR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(rear_idx) < DEPTH); // R4

   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      32'(fill_cnt) <= DEPTH - 1); // R3

   AST_DROP_SETS_HWERR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && ring_full) |=> flags[2]); // R6

   AST_DROP_HOLDS_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && ring_full) |=> $stable(front_idx)); // R6

   AST_ERR_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flags[1]) || $rose(flags[2])) |-> !acq_running); // R7

   AST_IDLE_FRONT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_req |=> $stable(front_idx)); // R12

   AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mask == 8'h00) |-> !irq); // R9

endmodule

bind smp_ring_irq smp_ring_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_req    (acc_req),
   .ring_full  (ring_full),
   .front_idx  (front_idx),
   .rear_idx   (rear_idx),
   .fill_cnt   (fill_cnt),
   .flags      (flags),
   .irq_mask   (irq_mask),
   .irq        (irq),
   .acq_running(acq_running)
);

// File: tb/tb_smp_ring_irq.sv
`timescale 1ns/1ps
module tb_smp_ring_irq;

   localparam int DATA_W = 16;
   localparam int DEPTH  = 2003;
   localparam int IDX_W  = 11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              acq_start = 0, acq_stop = 0, smp_valid = 0;
   logic [DATA_W-1:0] smp_data = '0;
   logic [IDX_W-1:0]  host_rd_addr = '0;
   logic [DATA_W-1:0] host_rd_data;
   logic              rear_wr = 0, thr_wr = 0, mask_wr = 0;
   logic [IDX_W-1:0]  rear_wdata = '0, thr_wdata = '0;
   logic [7:0]        mask_wdata = '0, flag_clr = '0, evt_set = '0;
   logic [IDX_W-1:0]  front_idx, rear_idx, fill_cnt;
   logic              acq_running, irq;
   logic [7:0]        flags, irq_mask;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   smp_ring_irq #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) dut (.*);

   // npush, rear write value, expected front, expected rear, expected fill
   localparam int VEC [7][5] = '{
      '{ 5,    0,  5,    0,  5},
      '{ 0,    3,  5,    3,  2},
      '{10,    3, 15,    3, 12},
      '{ 0,   15, 15,   15,  0},
      '{ 3,   15, 18,   15,  3},
      '{ 0, 2000, 18, 2000, 21},
      '{ 0, 2003, 18, 2000, 21}
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic push(input int n, input int base);
      for (int i = 0; i < n; i++) begin
         smp_valid = 1'b1;
         smp_data  = DATA_W'(base + i);
         @(negedge clk);
      end
      smp_valid = 1'b0;
   endtask

   task automatic wr_rear(input int v);
      rear_wr = 1'b1; rear_wdata = IDX_W'(v);
      @(negedge clk);
      rear_wr = 1'b0;
   endtask

   task automatic wr_thr(input int v);
      thr_wr = 1'b1; thr_wdata = IDX_W'(v);
      @(negedge clk);
      thr_wr = 1'b0;
   endtask

   task automatic wr_mask(input logic [7:0] v);
      mask_wr = 1'b1; mask_wdata = v;
      @(negedge clk);
      mask_wr = 1'b0;
   endtask

   task automatic clr(input logic [7:0] v);
      flag_clr = v;
      @(negedge clk);
      flag_clr = '0;
   endtask

   task automatic evt(input logic [7:0] v);
      evt_set = v;
      @(negedge clk);
      evt_set = '0;
   endtask

   task automatic start();
      acq_start = 1'b1; @(negedge clk); acq_start = 1'b0;
   endtask

   task automatic stop();
      acq_stop = 1'b1; @(negedge clk); acq_stop = 1'b0;
   endtask

   task automatic rd(input int a, input int exp, input string req);
      host_rd_addr = IDX_W'(a);
      @(negedge clk);
      check(req, int'(host_rd_data), exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1 reset state
      check("R1 front", int'(front_idx), 0);
      check("R1 rear", int'(rear_idx), 0);
      check("R1 fill", int'(fill_cnt), 0);
      check("R1 flags", int'(flags), 0);
      check("R1 mask", int'(irq_mask), 0);
      check("R1 irq", int'(irq), 0);
      check("R1 run", int'(acq_running), 0);

      // R12 stopped block ignores samples
      push(2, 16'h0050);
      check("R12 idle push", int'(front_idx), 0);
      start();
      check("R12 running", int'(acq_running), 1);

      // table walk: R2 R3 R4
      for (int k = 0; k < 7; k++) begin
         push(VEC[k][0], 16'h0100 + k * 16);
         wr_rear(VEC[k][1]);
         check("R2 front", int'(front_idx), VEC[k][2]);
         check("R4 rear", int'(rear_idx), VEC[k][3]);
         check("R3 fill", int'(fill_cnt), VEC[k][4]);
      end
      rd(2, 16'h0102, "R11 read addr2");
      rd(7, 16'h0122, "R11 read addr7");

      // threshold and interrupt
      do_reset();
      start();
      wr_thr(4);
      wr_mask(8'h01);
      push(3, 16'h0200);
      check("R5 below thr", int'(flags[0]), 0);
      check("R9 irq low", int'(irq), 0);
      push(1, 16'h0203);
      check("R5 at thr", int'(flags[0]), 1);
      check("R9 irq high", int'(irq), 1);
      wr_mask(8'h00);
      check("R9 mask zero", int'(irq), 0);
      wr_mask(8'h01);
      clr(8'h01);
      check("R8 w1c", int'(flags[0]), 0);
      check("R8 w1c irq", int'(irq), 0);

      // R8 set beats clear in the same cycle
      wr_thr(5);
      smp_valid = 1'b1; smp_data = 16'h0204; flag_clr = 8'h01;
      @(negedge clk);
      smp_valid = 1'b0; flag_clr = 8'h00;
      check("R8 set wins", int'(flags[0]), 1);

      // R3 push and rear write together
      smp_valid = 1'b1; smp_data = 16'h0205; rear_wr = 1'b1; rear_wdata = 11'd2;
      @(negedge clk);
      smp_valid = 1'b0; rear_wr = 1'b0;
      check("R3 concurrent front", int'(front_idx), 6);
      check("R3 concurrent rear", int'(rear_idx), 2);
      check("R3 concurrent fill", int'(fill_cnt), 4);

      // R10 event bit 7
      clr(8'hFF);
      wr_mask(8'h80);
      evt(8'h80);
      check("R10 evt bit7", int'(flags), 8'h80);
      check("R9 irq bit7", int'(irq), 1);

      // R7 software fault stops acquisition
      evt(8'h02);
      check("R7 sw err run", int'(acq_running), 0);
      push(1, 16'h0300);
      check("R7 push ignored", int'(front_idx), 6);
      // R7 error beats start
      acq_start = 1'b1; evt_set = 8'h02;
      @(negedge clk);
      acq_start = 1'b0; evt_set = 8'h00;
      check("R7 err over start", int'(acq_running), 0);
      start();
      stop();
      check("R12 stopped", int'(acq_running), 0);
      push(1, 16'h0301);
      check("R12 stopped push", int'(front_idx), 6);
      start();
      push(1, 16'h0302);
      check("R12 push ok", int'(front_idx), 7);

      // R6 overflow, then R2 wrap
      do_reset();
      start();
      push(DEPTH, 16'h2000);
      check("R6 front held", int'(front_idx), DEPTH - 1);
      check("R6 hw err flag", int'(flags[2]), 1);
      check("R6 fill full", int'(fill_cnt), DEPTH - 1);
      check("R7 hw err run", int'(acq_running), 0);
      rd(DEPTH - 2, 16'h2000 + DEPTH - 2, "R6 last kept word");
      rd(0, 16'h2000, "R6 first word intact");
      wr_rear(1000);
      clr(8'h04);
      start();
      push(1, 16'h3000);
      check("R2 wrap front", int'(front_idx), 0);
      check("R3 wrap fill", int'(fill_cnt), DEPTH - 1000);
      rd(DEPTH - 1, 16'h3000, "R2 wrap word");

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule